// File: doc/BRIEF.md
# Single-Byte SPI Master Peripheral

This block is an SPI master that moves one byte at a time. There is no FIFO behind it. Software programs it through a small byte-wide register file. It selects a clock polarity, sampling phase, bit order and divisor, loads a transmit byte, and sets a start bit. The shift engine then runs eight SCK cycles. It drives MOSI and collects eight bits from MISO, or from its own MOSI when internal loopback is selected. At the end it latches the received byte, raises a receive-ready flag and asserts an interrupt line.

The port is meant to serve as the host-side end of a slow serial bus. Every byte costs one interrupt. The clock divisor trades bus speed against how often that interrupt fires. Chip selects are generated elsewhere.

Top module: `spi_byte_master`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0x00, SCK and MOSI are low, and the interrupt is low.
- R2: The registers sit at byte offsets mode=0, receive data=1, transmit data=2, control=3, status=4 and divisor=6. Mode, transmit data and divisor read back what was written, and only the low five mode bits are stored. Offsets 5 and 7 and the control register read 0x00.
- R3: Writing the control register with bit 0 (value 0x01) set starts one transfer when the port is enabled and idle. From the next clock, status bit 1 (value 0x02) reads as busy.
- R4: Each SCK half period lasts 2×(divisor+1) clocks, so SCK runs at the clock divided by 4×(divisor+1). This holds for any divisor from 0 to 255. A transfer makes exactly 16 SCK edges.
- R5: Mode bit 1 (0x02) selects the SCK idle level: 1 for high, 0 for low. SCK rests at that level whenever no transfer runs.
- R6: Mode bit 4 (0x10) set makes the master sample on the leading SCK edge. MOSI then presents the first bit before that edge and changes on trailing edges. With the bit clear, MOSI changes on leading edges and sampling happens on trailing edges.
- R7: Mode bit 2 (0x04) clear shifts the MSB first in both directions. Set, it shifts the LSB first.
- R8: Mode bit 0 (0x01) set takes receive bits from the master's own MOSI, so the received byte equals the transmitted byte whatever MISO does.
- R9: Busy clears one clock after the final SCK edge. In that same clock, status bit 0 (0x01) sets, the interrupt rises, and the received byte becomes readable at offset 1.
- R10: Reading offset 1 clears receive-ready and the interrupt. If that read lands on the clock in which a transfer completes, the completion wins: ready and the interrupt stay set, and the read returns the previous byte.
- R11: A start request made while busy is ignored. The running transfer keeps the byte it latched at its start, and no second transfer follows.
- R12: With mode bit 3 (0x08, port enable) clear, the port stays quiet when idle. SCK holds the idle level, MOSI holds low, and start requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and shift clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 8 | Read data, valid the clock after the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Byte-complete interrupt, level |

## Verification
A read of the receive-data register and the completion of a transfer can fall in the same clock. That read would clear the ready flag at the very moment the completion sets it. The bench provokes this by counting clocks from the start write. With divisor 0 and the previous byte still unread, it places the read strobe on clock 33 after the start. It then expects the old byte on the bus, the status to still show ready, the interrupt to stay high, and a second read to return the new byte.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

  // register offsets; the control/status bit positions below are decoded by software
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_MODE = 3'd0,
    RA_RXD  = 3'd1,
    RA_TXD  = 3'd2,
    RA_CTRL = 3'd3,
    RA_STAT = 3'd4,
    RA_DIV  = 3'd6
  } reg_addr_e;

  // mode byte, bit 4 down to bit 0
  typedef struct packed {
    logic lead_sample;  // sample on leading edge (inverse of CPHA)
    logic enable;       // port enable
    logic lsb_first;    // bit order
    logic idle_high;    // SCK idle level (CPOL)
    logic loopback;     // receive from own MOSI
  } mode_t;

  localparam int MODE_W         = $bits(mode_t);
  localparam int CTRL_GO_BIT    = 0;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_BUSY_BIT  = 1;

endpackage

// File: rtl/spi_byte_clkgen.sv
module spi_byte_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  // half period is 2*(div+1) clocks, terminal count 2*div+1
  assign half_m1 = {div, 1'b1};
  assign tick    = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_byte,
  input  mode_t             mode,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              run,
  output logic              fin,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int EW = $clog2(2 * DATA_W);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W - 1);
  localparam logic [IW-1:0] LAST_BIT  = IW'(DATA_W - 1);

  logic [EW-1:0]     edge_cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] txb;
  logic [DATA_W-1:0] rxb;
  logic              sck_q;
  logic              mosi_q;
  logic              run_q;
  logic              fin_q;
  logic              bit_in;

  function automatic logic pick(input logic [DATA_W-1:0] b, input int unsigned i,
                                input logic lsb);
    return lsb ? b[i] : b[DATA_W-1-i];
  endfunction

  function automatic int unsigned slot(input int unsigned i, input logic lsb);
    return lsb ? i : (DATA_W - 1 - i);
  endfunction

  assign bit_in = mode.loopback ? mosi_q : miso;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      idx      <= '0;
      txb      <= '0;
      rxb      <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (!run_q) begin
        sck_q <= mode.idle_high;
        if (!mode.enable) begin
          mosi_q <= 1'b0;
        end
        if (start) begin
          run_q    <= 1'b1;
          txb      <= tx_byte;
          edge_cnt <= '0;
          idx      <= '0;
          mosi_q   <= pick(tx_byte, 0, mode.lsb_first);
        end
      end else if (tick) begin
        sck_q    <= ~sck_q;
        edge_cnt <= edge_cnt + EW'(1);
        if (!edge_cnt[0]) begin
          // leading edge
          if (mode.lead_sample) begin
            rxb[slot(idx, mode.lsb_first)] <= bit_in;
          end else begin
            mosi_q <= pick(txb, idx, mode.lsb_first);
          end
        end else begin
          // trailing edge
          if (mode.lead_sample) begin
            if (idx != LAST_BIT) begin
              mosi_q <= pick(txb, idx + 1, mode.lsb_first);
            end
          end else begin
            rxb[slot(idx, mode.lsb_first)] <= bit_in;
          end
          idx <= idx + IW'(1);
          if (edge_cnt == LAST_EDGE) begin
            run_q <= 1'b0;
            fin_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign run     = run_q;
  assign fin     = fin_q;
  assign rx_byte = rxb;
endmodule

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              rd_rx,
  input  logic              xfer_fin,
  input  logic [DATA_W-1:0] shift_rx,
  output mode_t             mode_q,
  output logic [DATA_W-1:0] tx_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy_q,
  output logic              ready_q,
  output logic              irq_q,
  output logic              start,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] rd_mux;
  logic [1:0]        stat;

  assign start = bus_wr && (bus_addr == RA_CTRL) && bus_wdata[CTRL_GO_BIT]
                 && mode_q.enable && !busy_q;

  always_comb begin
    stat                 = '0;
    stat[STAT_BUSY_BIT]  = busy_q;
    stat[STAT_READY_BIT] = ready_q;
  end

  always_comb begin
    case (bus_addr)
      RA_MODE: rd_mux = DATA_W'(mode_q);
      RA_RXD:  rd_mux = rx_q;
      RA_TXD:  rd_mux = tx_q;
      RA_STAT: rd_mux = DATA_W'(stat);
      RA_DIV:  rd_mux = DATA_W'(div_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      tx_q      <= '0;
      div_q     <= '0;
      rx_q      <= '0;
      busy_q    <= 1'b0;
      ready_q   <= 1'b0;
      irq_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RA_MODE: mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
          RA_TXD:  tx_q   <= bus_wdata;
          RA_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
      if (start) begin
        busy_q <= 1'b1;
      end else if (xfer_fin) begin
        busy_q <= 1'b0;
      end
      if (xfer_fin) begin
        rx_q <= shift_rx;
      end
      // completion outranks a clearing read in the same clock
      if (xfer_fin) begin
        ready_q <= 1'b1;
        irq_q   <= 1'b1;
      end else if (rd_rx) begin
        ready_q <= 1'b0;
        irq_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  mode_t             mode_q;
  logic [DATA_W-1:0] tx_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] shift_rx;
  logic              busy;
  logic              ready;
  logic              start;
  logic              run;
  logic              fin;
  logic              tick;
  logic              rd_rx;

  assign rd_rx = bus_rd && (bus_addr == RA_RXD);

  spi_byte_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_rx(rd_rx),
    .xfer_fin(fin), .shift_rx(shift_rx), .mode_q(mode_q), .tx_q(tx_q),
    .div_q(div_q), .busy_q(busy), .ready_q(ready), .irq_q(irq),
    .start(start), .bus_rdata(bus_rdata)
  );

  spi_byte_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(run), .div(div_q), .tick(tick)
  );

  spi_byte_shift #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .tx_byte(tx_q),
    .mode(mode_q), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .run(run), .fin(fin), .rx_byte(shift_rx)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sck,
  input logic             mosi,
  input logic             irq,
  input logic             busy,
  input logic             ready,
  input logic             idle_high,
  input logic             enable,
  input logic [DIV_W-1:0] div,
  input logic             rd_rx
);
  logic [DIV_W+2:0] gap;
  logic [7:0]       nedge;
  logic             sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= '0;
      nedge <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_d <= sck;
      if (!busy) begin
        gap   <= '0;
        nedge <= '0;
      end else if (sck != sck_d) begin
        gap   <= (DIV_W+3)'(1);
        nedge <= nedge + 8'd1;
      end else begin
        gap <= gap + (DIV_W+3)'(1);
      end
    end
  end

  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && $stable(idle_high)) |-> (sck == idle_high));

  assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!enable && !busy && $stable(enable)) |-> !mosi);

  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($fell(busy) && $rose(ready)));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !busy) |=> (!ready && !irq));

  assert_half_period_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && sck != sck_d) |-> (gap == (DIV_W+3)'(2 * (int'(div) + 1))));

  assert_one_byte_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (nedge == 8'(2 * DATA_W)));
endmodule

bind spi_byte_master spi_byte_master_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .sck(spi_sck), .mosi(spi_mosi), .irq(irq),
  .busy(busy), .ready(ready), .idle_high(mode_q.idle_high),
  .enable(mode_q.enable), .div(div_q), .rd_rx(rd_rx)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_mosi, spi_miso, irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // slave model state
  logic [7:0] sl_byte = '0;
  logic [7:0] cap = '0;
  logic       cur_lead = 1'b0;
  logic       cur_lsb = 1'b0;
  logic       sl_active = 1'b0;
  int         sl_edges = 0;
  int         t1 = 0;
  int         t2 = 0;

  // {mode, divisor, tx, slave byte, expected rx}
  localparam logic [39:0] VEC [8] = '{
    40'h18_00_A5_3C_3C,
    40'h08_01_5A_C3_C3,
    40'h1A_00_81_7E_7E,
    40'h0A_02_96_11_11,
    40'h1C_00_01_80_80,
    40'h0E_01_6B_D2_D2,
    40'h09_00_E7_00_E7,
    40'h1F_00_3D_C0_3D
  };

  always #10 clk = ~clk;  // 20 ns period

  always @(posedge clk) cyc = cyc + 1;

  spi_byte_master dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
  );

  always_comb begin
    int k;
    if (cur_lead) k = sl_edges / 2;
    else k = (sl_edges == 0) ? 0 : (sl_edges - 1) / 2;
    if (k > 7) k = 7;
    spi_miso = cur_lsb ? sl_byte[k] : sl_byte[7-k];
  end

  always @(spi_sck) begin
    if (sl_active) begin
      sl_edges = sl_edges + 1;
      if (sl_edges == 1) t1 = cyc;
      if (sl_edges == 2) t2 = cyc;
      if ((cur_lead && sl_edges[0]) || (!cur_lead && !sl_edges[0])) begin
        int k;
        k = (sl_edges - 1) / 2;
        if (k < 8) cap[cur_lsb ? k : 7-k] = spi_mosi;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic prep(input logic [7:0] m, input logic [7:0] dv,
                      input logic [7:0] tx, input logic [7:0] sl);
    wr(3'd0, m); wr(3'd6, dv); wr(3'd2, tx);
    sl_byte = sl; cur_lead = m[4]; cur_lsb = m[2];
    repeat (2) @(negedge clk);
    sl_edges = 0; cap = '0; sl_active = 1'b1;
  endtask

  task automatic go_wait(output int n);
    wr(3'd3, 8'h01);
    n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
    sl_active = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 map
    check("R1", "sck", spi_sck, 0);
    check("R1", "mosi", spi_mosi, 0);
    check("R1", "irq", irq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1", $sformatf("reg %0d", a), d, 0);
    end

    // R2 readback
    wr(3'd0, 8'h15); rd(3'd0, d); check("R2", "mode", d, 8'h15);
    wr(3'd2, 8'hC9); rd(3'd2, d); check("R2", "txd", d, 8'hC9);
    wr(3'd6, 8'h37); rd(3'd6, d); check("R2", "div", d, 8'h37);
    rd(3'd5, d); check("R2", "offset 5", d, 0);
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2", "mode width", d, 8'h1F);
    rd(3'd3, d); check("R2", "ctrl reads 0", d, 0);

    // R12 disabled port with idle-high clock
    wr(3'd0, 8'h02);
    repeat (2) @(negedge clk);
    check("R5", "idle high", spi_sck, 1);
    check("R12", "mosi low", spi_mosi, 0);
    wr(3'd3, 8'h01);
    repeat (40) @(negedge clk);
    rd(3'd4, d); check("R12", "status after start", d, 0);
    check("R12", "irq", irq, 0);
    check("R12", "sck held", spi_sck, 1);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [7:0] m, dv, tx, sl, ex;
      string rq;
      {m, dv, tx, sl, ex} = VEC[v];
      rq = m[0] ? "R8" : (m[2] ? "R7" : "R6");
      prep(m, dv, tx, sl);
      go_wait(n);
      check(rq, $sformatf("mosi byte v%0d", v), cap, tx);
      check("R4", $sformatf("edges v%0d", v), sl_edges, 16);
      check("R4", $sformatf("half period v%0d", v), t2 - t1, 2 * (int'(dv) + 1));
      check("R5", $sformatf("idle after v%0d", v), spi_sck, m[1]);
      rd(3'd4, d); check("R9", $sformatf("ready v%0d", v), d, 8'h01);
      rd(3'd1, d); check(rq, $sformatf("rx v%0d", v), d, ex);
      rd(3'd4, d); check("R10", $sformatf("cleared v%0d", v), d, 0);
      check("R10", $sformatf("irq low v%0d", v), irq, 0);
    end

    // R9 exact completion clock, divisor 3
    prep(8'h18, 8'h03, 8'h00, 8'h00);
    go_wait(n);
    check("R9", "clocks to irq", n, 16 * 8 + 1);
    rd(3'd1, d);

    // R3 busy, R11 start while busy ignored
    prep(8'h18, 8'h01, 8'hA5, 8'h66);
    wr(3'd3, 8'h01);
    rd(3'd4, d); check("R3", "busy", d, 8'h02);
    wr(3'd2, 8'h5A);
    wr(3'd3, 8'h01);
    n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    repeat (100) @(negedge clk);
    sl_active = 1'b0;
    check("R11", "mosi kept", cap, 8'hA5);
    check("R11", "single byte edges", sl_edges, 16);
    rd(3'd4, d); check("R11", "no restart", d, 8'h01);
    rd(3'd1, d); check("R11", "rx", d, 8'h66);

    // R10 collision: previous byte left unread
    prep(8'h18, 8'h00, 8'h00, 8'h11);
    go_wait(n);
    prep(8'h18, 8'h00, 8'h00, 8'h22);
    wr(3'd3, 8'h01);
    repeat (32) @(negedge clk);
    bus_addr = 3'd1; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    sl_active = 1'b0;
    check("R10", "collision old byte", d, 8'h11);
    check("R10", "collision irq", irq, 1);
    rd(3'd4, d); check("R10", "collision ready", d, 8'h01);
    rd(3'd1, d); check("R10", "new byte", d, 8'h22);

    // R4 maximum divisor
    prep(8'h18, 8'hFF, 8'hC3, 8'h5A);
    go_wait(n);
    check("R4", "max div half period", t2 - t1, 512);
    check("R4", "max div edges", sl_edges, 16);
    rd(3'd1, d); check("R6", "max div rx", d, 8'h5A);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule